// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block sits on the device side of an asynchronous DRAM interface and decides, for every row cycle, which operation the host is asking for. It watches the row strobe, a set of byte-lane column strobes, the write strobe and the output-enable strobe, all active low. It separates ordinary accesses from three forms of refresh using only the order in which the row and column strobe edges arrive. The strobes and the address are brought into a fast system clock domain through a two-flop synchroniser, and all edge decisions are made on the synchronised copies.

When a cycle opens, the block emits a one-cycle refresh pulse together with the row to activate. That row comes either from the address pins or from an internal refresh row counter, which wraps around. Each column strobe fall inside an externally addressed row produces a one-cycle access pulse carrying the open row and the read/write direction. The block also works out, per byte lane, whether the data pins should be driven. The extended-data-out hold rule applies: read data stays on the pins after the column strobe rises, and is released only once both the row strobe and that lane's column strobe are high.

Top module: `dram_strobe_classifier`

## Requirements
- R1: After reset, refreshPulse and accessPulse are 0, cycleKind is 0 (idle), dataOe is all zero and the internal row counter holds 0.
- R2: A row strobe fall while every column strobe is high opens a row-only cycle (cycleKind 1). It raises refreshPulse for one cycle with refreshRow equal to the address pins, and dataOe stays all zero.
- R3: Each transition from "all column strobes high" to "some column strobe low" while the row strobe is low in a row-only or access cycle raises accessPulse for one cycle. accessRow is the row opened at the row strobe fall, and accessWrite is 1 when the write strobe is low. cycleKind becomes 2 (access).
- R4: A row strobe fall while at least one column strobe is already low, and no lane holds read data, is a column-before-row refresh (cycleKind 3). refreshRow is the internal counter, and dataOe is all zero whatever the output-enable and write strobes are.
- R5: A row strobe fall while a column strobe is still held low from a preceding read, with that lane still holding read data, is a hidden refresh (cycleKind 4). refreshRow is the internal counter, and the lanes keep their previous dataOe.
- R6: The internal counter advances by one, modulo 2^ROW_BITS (4096 by default, 2048 with ROW_BITS = 11), after each column-before-row or hidden refresh. Row-only and access cycles leave it unchanged.
- R7: A lane whose column strobe falls in a read access drives its data (dataOe bit set while output enable is low). It keeps driving after its column strobe rises while the row strobe is low, and also while the row strobe is high with its column strobe low. The lane goes high-impedance once both are high.
- R8: A lane never drives after a write access, and any lane stops driving while the output-enable strobe is high.
- R9: refreshPulse, accessPulse and cycleKind change on the third rising clock edge after the strobe transition that causes them. Pulses last one cycle. cycleKind holds until the row strobe rises and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | LANES | Per-lane column strobes, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output-enable strobe, active low |
| addr | input | ROW_BITS | Multiplexed address pins |
| refreshPulse | output | 1 | One-cycle pulse when a row is opened |
| refreshRow | output | ROW_BITS | Row opened by the last refreshPulse |
| accessPulse | output | 1 | One-cycle pulse per column access |
| accessRow | output | ROW_BITS | Row of the last access |
| accessWrite | output | 1 | Direction of the last access, 1 = write |
| cycleKind | output | 3 | 0 idle, 1 row-only, 2 access, 3 column-before-row, 4 hidden |
| dataOe | output | LANES | Per-lane data pin drive enable |

## Verification
Pulses and the cycle kind are due on the third rising edge after a strobe change: two synchroniser flops, then the registered decision. The bench drives just after a falling edge and reads the sample-cycle index of every pulse at the following falling edges, expecting an offset of exactly three. Lane enables depend on both a registered lane state and the synchronised output-enable strobe, so they are due three edges after a column strobe change and two after an output-enable change. Every level check therefore waits four edges after the last input change. Expected rows, kinds and lane masks come from a bench-side counter model and small functions of the stimulus, over directed cases, a full counter wrap and a seeded random mix of cycle types.

// File: rtl/dram_cls_pkg.sv
package dram_cls_pkg;

  typedef enum logic [2:0] {
    KIND_IDLE    = 3'd0,
    KIND_ROWONLY = 3'd1,
    KIND_ACCESS  = 3'd2,
    KIND_CBR     = 3'd3,
    KIND_HIDDEN  = 3'd4
  } cycleKind_e;

  // Control-to-datapath strobes, valid for one clock.
  typedef struct packed {
    logic openExt;    // open row from the address pins
    logic openCnt;    // open row from the refresh counter, then advance it
    logic fireAccess; // column access inside the open row
    logic accessWr;   // direction of that access
  } dpStrobe_t;

endpackage

// File: rtl/dram_strobe_sync.sv
module dram_strobe_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_cls_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasS,
  input  logic [LANES-1:0] casS,
  input  logic             weS,
  input  logic             oeS,
  output dpStrobe_t        strobe,
  output cycleKind_e       kind,
  output logic [LANES-1:0] dataOe
);

  logic             rasQ;
  logic [LANES-1:0] casQ;
  logic [LANES-1:0] laneLive;
  cycleKind_e       kindNext;

  logic rasFall, rasRise, anyCasLow, casGroupFall, holding, hiddenStart, rowOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasQ <= 1'b1;
      casQ <= '1;
    end else begin
      rasQ <= rasS;
      casQ <= casS;
    end
  end

  assign rasFall      = rasQ & ~rasS;
  assign rasRise      = ~rasQ & rasS;
  assign anyCasLow    = ~&casS;
  assign casGroupFall = (&casQ) & anyCasLow;
  assign holding      = |laneLive;
  assign hiddenStart  = rasFall & anyCasLow & holding;
  assign rowOpen      = (kind == KIND_ROWONLY) || (kind == KIND_ACCESS);

  always_comb begin
    strobe.openExt    = rasFall & ~anyCasLow;
    strobe.openCnt    = rasFall & anyCasLow;
    strobe.fireAccess = ~rasS & ~rasFall & casGroupFall & rowOpen;
    strobe.accessWr   = ~weS;
  end

  always_comb begin
    kindNext = kind;
    if (rasRise)                kindNext = KIND_IDLE;
    else if (rasFall)           kindNext = anyCasLow ? (holding ? KIND_HIDDEN : KIND_CBR)
                                                     : KIND_ROWONLY;
    else if (strobe.fireAccess) kindNext = KIND_ACCESS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) kind <= KIND_IDLE;
    else       kind <= kindNext;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic laneFall;
    assign laneFall = casQ[g] & ~casS[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              laneLive[g] <= 1'b0;
      else if (rasFall && !hiddenStart)       laneLive[g] <= 1'b0;
      else if (!rasS && laneFall && rowOpen)  laneLive[g] <= weS;
      else if (rasS && casS[g])               laneLive[g] <= 1'b0;
    end
  end

  assign dataOe = laneLive & {LANES{~oeS}};

  // R4: a column-before-row refresh never drives the data pins
  assert_cbr_hiz_R4: assert property (@(posedge clk) disable iff (!rstN)
    kind == KIND_CBR |-> dataOe == '0);

  // R2: a row-only cycle never drives the data pins
  assert_rowonly_hiz_R2: assert property (@(posedge clk) disable iff (!rstN)
    kind == KIND_ROWONLY |-> dataOe == '0);

  // R5: a hidden refresh keeps the lanes that were holding read data
  assert_hidden_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    hiddenStart |=> (kind == KIND_HIDDEN) && (laneLive == $past(laneLive)));

  // R9: with the row strobe high the next cycle is idle
  assert_idle_when_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    rasS |=> kind == KIND_IDLE);

endmodule

// File: rtl/dram_row_datapath.sv
module dram_row_datapath
  import dram_cls_pkg::*;
#(
  parameter int ROW_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [ROW_BITS-1:0] addrS,
  output logic                refreshPulse,
  output logic [ROW_BITS-1:0] refreshRow,
  output logic                accessPulse,
  output logic [ROW_BITS-1:0] accessRow,
  output logic                accessWrite
);

  localparam logic [ROW_BITS-1:0] CNT_ONE = ROW_BITS'(1);

  logic [ROW_BITS-1:0] rowCnt;
  logic [ROW_BITS-1:0] openRow;
  logic [ROW_BITS-1:0] pickRow;

  assign pickRow = strobe.openExt ? addrS : rowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowCnt       <= '0;
      openRow      <= '0;
      refreshPulse <= 1'b0;
      refreshRow   <= '0;
    end else begin
      refreshPulse <= strobe.openExt | strobe.openCnt;
      if (strobe.openExt || strobe.openCnt) begin
        openRow    <= pickRow;
        refreshRow <= pickRow;
      end
      if (strobe.openCnt) rowCnt <= rowCnt + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accessPulse <= 1'b0;
      accessRow   <= '0;
      accessWrite <= 1'b0;
    end else begin
      accessPulse <= strobe.fireAccess;
      if (strobe.fireAccess) begin
        accessRow   <= openRow;
        accessWrite <= strobe.accessWr;
      end
    end
  end

  // R6: each counter-sourced refresh advances the counter by one, wrapping
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.openCnt |=> rowCnt == $past(rowCnt) + CNT_ONE);

  // R6: other cycles leave the counter alone
  assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.openCnt |=> $stable(rowCnt));

  // R9: refresh pulse lasts one cycle
  assert_refresh_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    refreshPulse |=> !refreshPulse);

  // R3: an access never coincides with a row opening
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(refreshPulse && accessPulse));

endmodule

// File: rtl/dram_strobe_classifier.sv
module dram_strobe_classifier
  import dram_cls_pkg::*;
#(
  parameter int ROW_BITS = 12,
  parameter int LANES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rasN,
  input  logic [LANES-1:0]    casN,
  input  logic                weN,
  input  logic                oeN,
  input  logic [ROW_BITS-1:0] addr,
  output logic                refreshPulse,
  output logic [ROW_BITS-1:0] refreshRow,
  output logic                accessPulse,
  output logic [ROW_BITS-1:0] accessRow,
  output logic                accessWrite,
  output logic [2:0]          cycleKind,
  output logic [LANES-1:0]    dataOe
);

  localparam int STROBE_W = LANES + 3;

  logic [STROBE_W-1:0] strobeRaw, strobeSync;
  logic [ROW_BITS-1:0] addrSync;
  dpStrobe_t           ctrlStrobe;
  cycleKind_e          kind;

  assign strobeRaw = {rasN, casN, weN, oeN};

  dram_strobe_sync #(.WIDTH(STROBE_W), .STAGES(SYNC_STAGES), .RESET_VAL({STROBE_W{1'b1}}))
    u_strobeSync (.clk(clk), .rstN(rstN), .din(strobeRaw), .dout(strobeSync));

  dram_strobe_sync #(.WIDTH(ROW_BITS), .STAGES(SYNC_STAGES), .RESET_VAL('0))
    u_addrSync (.clk(clk), .rstN(rstN), .din(addr), .dout(addrSync));

  dram_cycle_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .rasS(strobeSync[STROBE_W-1]),
    .casS(strobeSync[STROBE_W-2:2]),
    .weS(strobeSync[1]),
    .oeS(strobeSync[0]),
    .strobe(ctrlStrobe), .kind(kind), .dataOe(dataOe)
  );

  dram_row_datapath #(.ROW_BITS(ROW_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe), .addrS(addrSync),
    .refreshPulse(refreshPulse), .refreshRow(refreshRow),
    .accessPulse(accessPulse), .accessRow(accessRow), .accessWrite(accessWrite)
  );

  assign cycleKind = kind;

endmodule

// File: tb/tb_dram_strobe_classifier.sv
module tb_dram_strobe_classifier;

  localparam int RB = 12;
  localparam int LN = 4;
  localparam int ROWS = 1 << RB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1;
  logic [LN-1:0] casN = '1;
  logic weN = 1'b1, oeN = 1'b1;
  logic [RB-1:0] addr = '0;
  logic refreshPulse, accessPulse, accessWrite;
  logic [RB-1:0] refreshRow, accessRow;
  logic [2:0] cycleKind;
  logic [LN-1:0] dataOe;

  dram_strobe_classifier #(.ROW_BITS(RB), .LANES(LN)) dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .refreshPulse(refreshPulse), .refreshRow(refreshRow),
    .accessPulse(accessPulse), .accessRow(accessRow), .accessWrite(accessWrite),
    .cycleKind(cycleKind), .dataOe(dataOe));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  int refCnt = 0, accCnt = 0, lastRefCyc = 0, lastAccCyc = 0;
  int lastRefRow = 0, lastAccRow = 0, lastAccWr = 0;
  int cntModel = 0;
  bit finished = 0;

  always @(negedge clk) begin
    cyc++;
    if (refreshPulse) begin refCnt++; lastRefCyc = cyc; lastRefRow = int'(refreshRow); end
    if (accessPulse)  begin accCnt++; lastAccCyc = cyc; lastAccRow = int'(accessRow); lastAccWr = int'(accessWrite); end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic int expLanes(bit wr, bit oeLow, int mask);
    return (!wr && oeLow) ? mask : 0;
  endfunction

  function automatic int nextCnt(int c);
    return (c + 1) % ROWS;
  endfunction

  task automatic doRowOnly(int row);
    int r0, t0;
    addr = RB'(row); waitCyc(4);
    r0 = refCnt; rasN = 1'b0; t0 = cyc; waitCyc(4);
    chk("R2", "refresh count", refCnt, r0 + 1);
    chk("R2", "refresh row", lastRefRow, row);
    chk("R9", "refresh latency", lastRefCyc - t0, 3);
    chk("R2", "kind", int'(cycleKind), 1);
    chk("R2", "dataOe", int'(dataOe), 0);
    rasN = 1'b1; waitCyc(4);
    chk("R9", "kind back to idle", int'(cycleKind), 0);
  endtask

  // Opens an external row and makes one column access; keepCas leaves the
  // column strobes low at the end for a following hidden refresh.
  task automatic doAccess(int row, int mask, bit wr, bit oeLow, bit keepCas);
    int a0, t0, ex;
    addr = RB'(row); weN = ~wr; oeN = ~oeLow; waitCyc(4);
    rasN = 1'b0; waitCyc(4);
    chk("R2", "opened row", lastRefRow, row);
    a0 = accCnt; casN = ~LN'(mask); t0 = cyc; waitCyc(4);
    ex = expLanes(wr, oeLow, mask);
    chk("R3", "access count", accCnt, a0 + 1);
    chk("R3", "access row", lastAccRow, row);
    chk("R3", "access write", lastAccWr, int'(wr));
    chk("R9", "access latency", lastAccCyc - t0, 3);
    chk("R3", "kind", int'(cycleKind), 2);
    chk(wr ? "R8" : "R7", "dataOe during access", int'(dataOe), ex);
    if (!keepCas) begin
      casN = '1; waitCyc(4);
      chk("R7", "EDO hold after column rise", int'(dataOe), ex);
      rasN = 1'b1; waitCyc(4);
      chk("R7", "release when all high", int'(dataOe), 0);
      chk("R9", "idle after row rise", int'(cycleKind), 0);
    end else begin
      rasN = 1'b1; waitCyc(4);
      chk("R7", "hold with column low", int'(dataOe), ex);
    end
  endtask

  task automatic doCbr(int mask, bit wLow, bit oLow);
    int r0, t0;
    weN = ~wLow; oeN = ~oLow; casN = ~LN'(mask); waitCyc(4);
    r0 = refCnt; rasN = 1'b0; t0 = cyc; waitCyc(4);
    chk("R4", "refresh count", refCnt, r0 + 1);
    chk("R6", "counter row", lastRefRow, cntModel);
    chk("R9", "refresh latency", lastRefCyc - t0, 3);
    chk("R4", "kind", int'(cycleKind), 3);
    chk("R4", "dataOe hi-z", int'(dataOe), 0);
    cntModel = nextCnt(cntModel);
    rasN = 1'b1; waitCyc(4);
    casN = '1; waitCyc(4);
  endtask

  // Read (or write) with column held low, then a second row strobe fall.
  task automatic doHidden(int row, int mask, bit wr, bit oeLow);
    int ex;
    doAccess(row, mask, wr, oeLow, 1'b1);
    ex = expLanes(wr, oeLow, mask);
    rasN = 1'b0; waitCyc(4);
    chk(wr ? "R4" : "R5", "kind", int'(cycleKind), wr ? 3 : 4);
    chk("R6", "counter row", lastRefRow, cntModel);
    chk("R5", "dataOe kept", int'(dataOe), ex);
    cntModel = nextCnt(cntModel);
    rasN = 1'b1; waitCyc(4);
    casN = '1; waitCyc(4);
    chk("R7", "release after hidden", int'(dataOe), 0);
  endtask

  initial begin
    void'($urandom(32'h1234ABCD));
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    chk("R1", "refreshPulse", int'(refreshPulse), 0);
    chk("R1", "accessPulse", int'(accessPulse), 0);
    chk("R1", "kind", int'(cycleKind), 0);
    chk("R1", "dataOe", int'(dataOe), 0);

    // First counter refresh shows the reset counter value (R1, R6).
    doCbr(4'b0001, 1'b0, 1'b1);
    chk("R1", "counter after reset", lastRefRow, 0);

    doRowOnly(12'hABC);
    doRowOnly(0);
    doRowOnly(ROWS - 1);

    // Read with output enable, then toggle output enable (R8).
    doAccess(12'h155, 4'b1010, 1'b0, 1'b1, 1'b1);
    oeN = 1'b1; waitCyc(4);
    chk("R8", "OE high disables", int'(dataOe), 0);
    oeN = 1'b0; waitCyc(4);
    chk("R8", "OE low re-enables", int'(dataOe), 4'b1010);
    casN = '1; waitCyc(4);
    chk("R7", "release after row and column high", int'(dataOe), 0);

    doAccess(12'h2AA, 4'b1111, 1'b1, 1'b1, 1'b0);
    doAccess(12'h0F0, 4'b0110, 1'b0, 1'b0, 1'b0);
    doCbr(4'b1111, 1'b1, 1'b0);
    doHidden(12'h321, 4'b0011, 1'b0, 1'b1);
    doHidden(12'h123, 4'b1100, 1'b1, 1'b1);
    doHidden(12'h777, 4'b0100, 1'b0, 1'b0);

    for (int i = 0; i < 80; i++) begin
      int row, mask;
      bit wr, oe;
      row  = int'($urandom % ROWS);
      mask = int'($urandom % 15) + 1;
      wr   = 1'($urandom % 2);
      oe   = 1'($urandom % 2);
      case ($urandom % 4)
        0: doRowOnly(row);
        1: doAccess(row, mask, wr, oe, 1'b0);
        2: doCbr(mask, wr, oe);
        default: doHidden(row, mask, wr, oe);
      endcase
    end

    // Full wrap of the refresh counter (R6).
    for (int i = 0; i < ROWS; i++) doCbr(1 << (i % LN), 1'b0, 1'b0);
    doRowOnly(12'h5A5);
    doCbr(4'b0001, 1'b0, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule